// File: doc/BRIEF.md
# FIFO Flag-Offset Register Bank

This block keeps the two threshold offsets that a FIFO's almost-empty and almost-full flag logic compares against. Each offset is split into a low part and a high part, which gives four small registers. They are written and read through the FIFO's own 9-bit data buses while an active-low load control is held low. No address is used. A rotating write pointer picks the register for each load write, and an independent rotating read pointer picks the register for each load readback. Both pointers step through the same fixed cycle: empty low, empty high, full low, full high, then back to empty low.

The flag logic reads the two assembled offsets all the time. Readback data appears on a registered output word. The FIFO depth is a parameter and sets how wide the offsets are. The low part is at most 8 bits wide. The high part holds whatever bits remain and may have no bits at all. The whole block runs on one shared clock.

Top module: `flag_offset_bank`

## Requirements
- R1: After reset, both assembled offsets equal 7, the readback word is 0, and both pointers sit at the empty-low register.
- R2: A clock edge with `load_n` low and `wen_n` low is a load write. Successive load writes store `din` into empty-low, empty-high, full-low and full-high, in that order. Each offset reads out as {high part, low part}.
- R3: The fifth load write in a row wraps around and stores into empty-low again.
- R4: While `load_n` is high the offsets do not change, whatever `wen_n` and `din` do. The write pointer keeps its position, so the next load write goes to the register after the last one written.
- R5: A clock edge with `load_n` low and both `ren1_n` and `ren2_n` low (and no load write) is a load read. It registers the register picked by the read pointer onto `rd_data` and then advances the read pointer through the same four-register cycle.
- R6: The low part is min(log2(DEPTH), 8) bits wide and the high part holds the remaining log2(DEPTH) minus that many bits. A load write ignores the `din` bits above a register's width. A load read returns those bits as zero, and a high part with no bits reads back as 0.
- R7: If a load write and a load read are requested on the same edge, only the write is performed. `rd_data` and the read pointer stay unchanged.
- R8: On any edge that is not a load read, `rd_data` holds its value. This includes edges where the read enables are low but `load_n` is high.
- R9: If only one of `ren1_n` and `ren2_n` is low, no load read takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_n | input | 1 | Load mode select, active low |
| wen_n | input | 1 | Write enable, active low |
| ren1_n | input | 1 | First read enable, active low |
| ren2_n | input | 1 | Second read enable, active low |
| din | input | 9 | Data input bus |
| rd_data | output | 9 | Registered offset readback word |
| empty_off | output | log2(DEPTH) | Assembled almost-empty offset |
| full_off | output | log2(DEPTH) | Assembled almost-full offset |

## Verification
The bench builds two copies of the block and drives them with the same stimulus. One copy has DEPTH 512, which gives an 8-bit low part and a 1-bit high part, so the {high, low} assembly and the masking of high-part bits can both be seen. The other copy has DEPTH 64, which gives a 6-bit low part and no high part, so the write sequence that skips storage and the zero readback can be checked. Pointer persistence and write-over-read priority are checked by choosing data so that a wrong pointer position shows up as a different value.

// File: rtl/flag_offset_pkg.sv
package flag_offset_pkg;
  typedef enum logic [1:0] {
    SLOT_EMPTY_LO = 2'd0,
    SLOT_EMPTY_HI = 2'd1,
    SLOT_FULL_LO  = 2'd2,
    SLOT_FULL_HI  = 2'd3
  } slot_e;

  localparam int unsigned NUM_SLOTS = 4;
  localparam int unsigned RESET_OFFSET = 7;
endpackage

// File: rtl/slot_ptr.sv
module slot_ptr
  import flag_offset_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  adv,
  output slot_e ptr
);
  slot_e ptr_d;

  always_comb begin
    ptr_d = ptr;
    if (adv) ptr_d = slot_e'(ptr + 2'd1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr <= SLOT_EMPTY_LO;
    else        ptr <= ptr_d;
  end
endmodule

// File: rtl/offset_store.sv
module offset_store
  import flag_offset_pkg::*;
#(
  parameter int unsigned DATA_W = 9,
  parameter int unsigned OFF_W  = 9,
  parameter int unsigned LO_W   = 8,
  parameter int unsigned HI_W   = 1
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             we,
  input  slot_e                            wslot,
  input  logic [DATA_W-1:0]                din,
  output logic [OFF_W-1:0]                 empty_off,
  output logic [OFF_W-1:0]                 full_off,
  output logic [NUM_SLOTS-1:0][DATA_W-1:0] view
);
  logic [LO_W-1:0] e_lo_q, e_lo_d, f_lo_q, f_lo_d;
  logic            e_lo_en, f_lo_en;

  assign e_lo_en = we && (wslot == SLOT_EMPTY_LO);
  assign f_lo_en = we && (wslot == SLOT_FULL_LO);
  assign e_lo_d  = e_lo_en ? din[LO_W-1:0] : e_lo_q;
  assign f_lo_d  = f_lo_en ? din[LO_W-1:0] : f_lo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_lo_q <= LO_W'(RESET_OFFSET);
      f_lo_q <= LO_W'(RESET_OFFSET);
    end else begin
      e_lo_q <= e_lo_d;
      f_lo_q <= f_lo_d;
    end
  end

  generate
    if (HI_W > 0) begin : g_hi
      logic [HI_W-1:0] e_hi_q, e_hi_d, f_hi_q, f_hi_d;
      logic            e_hi_en, f_hi_en;

      assign e_hi_en = we && (wslot == SLOT_EMPTY_HI);
      assign f_hi_en = we && (wslot == SLOT_FULL_HI);
      assign e_hi_d  = e_hi_en ? din[HI_W-1:0] : e_hi_q;
      assign f_hi_d  = f_hi_en ? din[HI_W-1:0] : f_hi_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          e_hi_q <= '0;
          f_hi_q <= '0;
        end else begin
          e_hi_q <= e_hi_d;
          f_hi_q <= f_hi_d;
        end
      end

      assign empty_off = {e_hi_q, e_lo_q};
      assign full_off  = {f_hi_q, f_lo_q};

      always_comb begin
        view = '0;
        view[SLOT_EMPTY_LO][LO_W-1:0] = e_lo_q;
        view[SLOT_EMPTY_HI][HI_W-1:0] = e_hi_q;
        view[SLOT_FULL_LO][LO_W-1:0]  = f_lo_q;
        view[SLOT_FULL_HI][HI_W-1:0]  = f_hi_q;
      end
    end else begin : g_no_hi
      assign empty_off = e_lo_q;
      assign full_off  = f_lo_q;

      always_comb begin
        view = '0;
        view[SLOT_EMPTY_LO][LO_W-1:0] = e_lo_q;
        view[SLOT_FULL_LO][LO_W-1:0]  = f_lo_q;
      end
    end
  endgenerate
endmodule

// File: rtl/readback_reg.sv
module readback_reg
  import flag_offset_pkg::*;
#(
  parameter int unsigned DATA_W = 9
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             re,
  input  slot_e                            rslot,
  input  logic [NUM_SLOTS-1:0][DATA_W-1:0] view,
  output logic [DATA_W-1:0]                rd_data
);
  logic [DATA_W-1:0] rd_d;

  always_comb begin
    rd_d = rd_data;
    if (re) rd_d = view[rslot];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= rd_d;
  end
endmodule

// File: rtl/flag_offset_bank.sv
module flag_offset_bank
  import flag_offset_pkg::*;
#(
  parameter int unsigned DEPTH  = 512,
  parameter int unsigned DATA_W = 9,
  localparam int unsigned OFF_W = $clog2(DEPTH),
  localparam int unsigned LO_W  = (OFF_W < 8) ? OFF_W : 8,
  localparam int unsigned HI_W  = OFF_W - LO_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_n,
  input  logic              wen_n,
  input  logic              ren1_n,
  input  logic              ren2_n,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] rd_data,
  output logic [OFF_W-1:0]  empty_off,
  output logic [OFF_W-1:0]  full_off
);
  logic  ld_wr, ld_rd;
  slot_e wr_slot, rd_slot;
  logic [NUM_SLOTS-1:0][DATA_W-1:0] slot_view;

  // Write wins when both are requested in load mode.
  assign ld_wr = !load_n && !wen_n;
  assign ld_rd = !load_n && !ren1_n && !ren2_n && !ld_wr;

  slot_ptr u_wr_ptr (.clk(clk), .rst_n(rst_n), .adv(ld_wr), .ptr(wr_slot));
  slot_ptr u_rd_ptr (.clk(clk), .rst_n(rst_n), .adv(ld_rd), .ptr(rd_slot));

  offset_store #(
    .DATA_W(DATA_W), .OFF_W(OFF_W), .LO_W(LO_W), .HI_W(HI_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .we(ld_wr), .wslot(wr_slot), .din(din),
    .empty_off(empty_off), .full_off(full_off), .view(slot_view)
  );

  readback_reg #(.DATA_W(DATA_W)) u_rdbk (
    .clk(clk), .rst_n(rst_n), .re(ld_rd), .rslot(rd_slot),
    .view(slot_view), .rd_data(rd_data)
  );
endmodule

// File: rtl/flag_offset_bank_chk.sv
module flag_offset_bank_chk #(
  parameter int unsigned DATA_W = 9,
  parameter int unsigned OFF_W  = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load_n,
  input logic              wen_n,
  input logic              ren1_n,
  input logic              ren2_n,
  input logic [DATA_W-1:0] rd_data,
  input logic [OFF_W-1:0]  empty_off,
  input logic [OFF_W-1:0]  full_off,
  input logic [1:0]        wptr,
  input logic [1:0]        rptr
);
  p_offsets_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load_n |=> ($stable(empty_off) && $stable(full_off)));

  p_wptr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load_n |=> $stable(wptr));

  p_wptr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_n && !wen_n) |=> (wptr == 2'($past(wptr) + 2'd1)));

  p_write_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_n && !wen_n) |=> ($stable(rptr) && $stable(rd_data)));

  p_rdata_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n || ren1_n || ren2_n) |=> $stable(rd_data));

  p_rptr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_n && wen_n && !ren1_n && !ren2_n) |=> (rptr == 2'($past(rptr) + 2'd1)));
endmodule

bind flag_offset_bank flag_offset_bank_chk #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .load_n(load_n), .wen_n(wen_n),
  .ren1_n(ren1_n), .ren2_n(ren2_n), .rd_data(rd_data),
  .empty_off(empty_off), .full_off(full_off),
  .wptr(wr_slot), .rptr(rd_slot)
);

// File: tb/flag_offset_bank_test.sv
module flag_offset_bank_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       load_n, wen_n, ren1_n, ren2_n;
  logic [8:0] din;
  logic [8:0] rd_big, rd_sml;
  logic [8:0] eo_big, fo_big;
  logic [5:0] eo_sml, fo_sml;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  flag_offset_bank #(.DEPTH(512)) uut (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .wen_n(wen_n),
    .ren1_n(ren1_n), .ren2_n(ren2_n), .din(din),
    .rd_data(rd_big), .empty_off(eo_big), .full_off(fo_big));

  flag_offset_bank #(.DEPTH(64)) uut_small (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .wen_n(wen_n),
    .ren1_n(ren1_n), .ren2_n(ren2_n), .din(din),
    .rd_data(rd_sml), .empty_off(eo_sml), .full_off(fo_sml));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Drive at the falling edge, let one rising edge pass, return at the next falling edge.
  task automatic step(logic ld, logic we, logic r1, logic r2, logic [8:0] d);
    load_n = ld; wen_n = we; ren1_n = r1; ren2_n = r2; din = d;
    @(negedge clk);
    load_n = 1'b1; wen_n = 1'b1; ren1_n = 1'b1; ren2_n = 1'b1;
  endtask

  task automatic t_reset();
    chk("R1 big empty_off", eo_big, 7);
    chk("R1 big full_off",  fo_big, 7);
    chk("R1 big rd_data",   rd_big, 0);
    chk("R1 small empty_off", eo_sml, 7);
    chk("R1 small full_off",  fo_sml, 7);
  endtask

  task automatic t_write_seq();
    step(0, 0, 1, 1, 9'h1A5);
    step(0, 0, 1, 1, 9'h1FF);
    step(0, 0, 1, 1, 9'h03C);
    step(0, 0, 1, 1, 9'h001);
    chk("R2 big empty_off", eo_big, 9'h1A5);
    chk("R2 big full_off",  fo_big, 9'h13C);
    chk("R6 small empty_off masked", eo_sml, 6'h25);
    chk("R6 small full_off", fo_sml, 6'h3C);
  endtask

  task automatic t_readback();
    step(0, 1, 0, 0, 9'h0);
    chk("R5 big read empty-lo", rd_big, 9'h0A5);
    chk("R6 small read empty-lo", rd_sml, 9'h025);
    step(0, 1, 0, 0, 9'h0);
    chk("R6 big read empty-hi zero-extended", rd_big, 9'h001);
    chk("R6 small read absent empty-hi", rd_sml, 0);
    step(0, 1, 0, 0, 9'h0);
    chk("R5 big read full-lo", rd_big, 9'h03C);
    step(0, 1, 0, 0, 9'h0);
    chk("R5 big read full-hi", rd_big, 9'h001);
    chk("R6 small read absent full-hi", rd_sml, 0);
  endtask

  task automatic t_wrap();
    step(0, 0, 1, 1, 9'h055);
    chk("R3 big wrap to empty-lo", eo_big, 9'h155);
    chk("R3 small wrap to empty-lo", eo_sml, 6'h15);
  endtask

  task automatic t_persist();
    step(1, 0, 1, 1, 9'h0EE);
    step(1, 0, 0, 0, 9'h0EE);
    chk("R4 big empty_off held", eo_big, 9'h155);
    chk("R4 big full_off held", fo_big, 9'h13C);
    chk("R8 rd_data held with load_n high", rd_big, 9'h001);
    step(0, 0, 1, 1, 9'h000);
    chk("R4 next write goes to empty-hi", eo_big, 9'h055);
    chk("R4 big full_off untouched", fo_big, 9'h13C);
  endtask

  task automatic t_priority();
    step(0, 0, 0, 0, 9'h077);
    chk("R7 write done to full-lo", fo_big, 9'h177);
    chk("R7 small write done", fo_sml, 6'h37);
    chk("R7 rd_data unchanged", rd_big, 9'h001);
    step(0, 1, 0, 0, 9'h0);
    chk("R7 read pointer did not move", rd_big, 9'h055);
    chk("R7 small read pointer did not move", rd_sml, 9'h015);
  endtask

  task automatic t_half_enable();
    step(0, 1, 0, 1, 9'h0);
    chk("R9 ren2_n high blocks read", rd_big, 9'h055);
    step(0, 1, 1, 0, 9'h0);
    chk("R9 ren1_n high blocks read", rd_big, 9'h055);
    step(0, 1, 0, 0, 9'h0);
    chk("R9 pointer still at empty-hi", rd_big, 9'h000);
  endtask

  initial begin
    load_n = 1'b1; wen_n = 1'b1; ren1_n = 1'b1; ren2_n = 1'b1; din = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_seq();
    t_readback();
    t_wrap();
    t_persist();
    t_priority();
    t_half_enable();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule